// File: doc/BRIEF.md
# Dual-Stage Clock Divider Register Controller

This block is the digital control front end of a two-stage clock synthesizer. Software writes divider settings over a plain write-only address/data bus. The first stage has an 8-bit input divider and an 8-bit feedback divider. The second stage has two 4-bit dividers that share one register. A separate ratio-select bit picks the fractional path of the second stage. Each stored value is one less than the divide ratio it stands for, so the divisor that downstream logic uses is the stored value plus one.

Writes go first into staging registers. They reach the live divider outputs only when the required sequence has completed. A first-stage pair commits only on an input-divider write that is followed directly by a feedback-divider write. A staged ratio-select bit takes effect only when the second-stage register is next written. Every commit starts a lock-wait window, and the window length depends on which stage changed and on the mode in force. While the window runs `busy` is high and `ready` is low.

Two state machines do the work. The write sequencer has the states `SQ_IDLE` and `SQ_ARMED`. It moves from `SQ_IDLE` to `SQ_ARMED` on an input-divider write. It returns from `SQ_ARMED` to `SQ_IDLE` on a feedback-divider write, which commits the pair, or on a write to any other address, which is an order error. A repeated input-divider write keeps it in `SQ_ARMED` and re-stages the value. The lock timer has the states `LK_WAIT` and `LK_LOCKED`. Any commit moves it to `LK_WAIT`, which also reloads the timer when it is already there. It moves from `LK_WAIT` to `LK_LOCKED` when the count expires. Reset enters `LK_WAIT` with a long window. A combinational check flags a committed first-stage input divider that would push the comparison frequency below 144 kHz.

Top module: `clkdiv_ctrl`

## Requirements
- R1: Reset sets all four divider outputs to 0, `ratio_mode` to 0 and all error flags to 0. It also starts a long lock window, so `busy` is 1 and `ready` is 0 until LONG_US*CYC_PER_US cycles after reset is released.
- R2: The first-stage pair commits only in one sequence: a write to address 7, which stages the input divider, then a write to address 8 as the very next write, which carries the feedback divider. Idle cycles may fall between the two writes. Both outputs change together after the address-8 write and stay unchanged before it.
- R3: A write to address 10 stages the ratio-select bit from data bit 0. `ratio_mode` keeps its value until the next write to address 9.
- R4: A write to address 9 commits the second-stage dividers at once. Data bits 7:4 set `stage2_in_div` and bits 3:0 set `stage2_fb_div`.
- R5: In these cases the sticky flag `order_err` is set and stays set until reset:
  - A write to address 7 is followed by a write to any other address. The staged value is then discarded. A following write to address 8 is ignored.
  - A write to address 8 arrives with no address-7 write directly before it. That write is ignored.
  - A write to address 7 arrives while another address-7 write is pending. It replaces the pending value.
- R6: A first-stage commit holds `busy` for LONG_US*CYC_PER_US cycles. A second-stage commit holds `busy` for SHORT_US*CYC_PER_US cycles when the resulting `ratio_mode` is 0, and for LONG_US*CYC_PER_US cycles when it is 1. `ready` is the complement of `busy`.
- R7: A commit that arrives while a window is running restarts the count. The new window is long if either the running window or the new commit calls for a long one.
- R8: A write of 0 to address 9 while the staged ratio bit is 1 still commits both dividers as 0. It sets the sticky flag `cfg_err`, leaves `ratio_mode` at its previous value and times the window for that previous mode.
- R9: `cmp_freq_low` is 1 exactly when MCLK_HZ < 144000*(stage1_in_div+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Write data |
| stage1_in_div | output | DW | Committed first-stage input divider (value minus one) |
| stage1_fb_div | output | DW | Committed first-stage feedback divider (value minus one) |
| stage2_in_div | output | DW/2 | Committed second-stage input divider (value minus one) |
| stage2_fb_div | output | DW/2 | Committed second-stage feedback divider (value minus one) |
| ratio_mode | output | 1 | Committed ratio-select bit |
| busy | output | 1 | Lock wait in progress |
| ready | output | 1 | Synthesizer settled |
| order_err | output | 1 | Sticky write-order violation |
| cfg_err | output | 1 | Sticky zero-with-ratio configuration error |
| cmp_freq_low | output | 1 | First-stage comparison frequency below 144 kHz |

## Verification
The sequencer is tried with four write patterns:
- A clean address-7 then address-8 pair with idle cycles in between. This shows that only the write sequence matters, not adjacency in time.
- A pair interrupted by a second-stage write. This separates discarding the staged value from processing the interrupting write.
- A lone address-8 write, which shows it is ignored.
- Mode writes with no following address-9 write, which tell deferred from immediate mode changes.

The timer is checked one cycle before and at the exact expiry edge for these cases:
- short second-stage commits
- long second-stage commits
- first-stage commits
- a short commit landing inside a long window, which tells a plain restart from the keep-the-longer rule

The comparison-frequency flag is probed on the two divider values that sit on either side of the 144 kHz limit.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic {
        SQ_IDLE,
        SQ_ARMED
    } seq_state_t;

    typedef enum logic {
        LK_WAIT,
        LK_LOCKED
    } lock_state_t;

endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int A_S1IN = 7,
    parameter int A_S1FB = 8,
    parameter int A_S2   = 9,
    parameter int A_MODE = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   s1_in,
    output logic [DW-1:0]   s1_fb,
    output logic [DW/2-1:0] s2_in,
    output logic [DW/2-1:0] s2_fb,
    output logic            mode,
    output logic            order_err,
    output logic            cfg_err,
    output logic            commit,
    output logic            commit_long
);
    localparam int HW = DW / 2;

    seq_state_t     state_q, state_d;
    logic           hit_in, hit_fb, hit_s2, hit_mode;
    logic           do_s1, do_s2, oerr_set, bad_zero, mode_next;
    logic [DW-1:0]  staged_in_q;
    logic           staged_mode_q;

    assign hit_in   = wr_en && (wr_addr == AW'(A_S1IN));
    assign hit_fb   = wr_en && (wr_addr == AW'(A_S1FB));
    assign hit_s2   = wr_en && (wr_addr == AW'(A_S2));
    assign hit_mode = wr_en && (wr_addr == AW'(A_MODE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next state and sequence strobes
    always_comb begin
        state_d  = state_q;
        do_s1    = 1'b0;
        oerr_set = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (hit_in)      state_d  = SQ_ARMED;
                else if (hit_fb) oerr_set = 1'b1;
            end
            SQ_ARMED: begin
                if (hit_fb) begin
                    do_s1   = 1'b1;
                    state_d = SQ_IDLE;
                end else if (hit_in) begin
                    oerr_set = 1'b1;
                end else if (wr_en) begin
                    oerr_set = 1'b1;
                    state_d  = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // second-stage commit and mode resolution
    always_comb begin
        do_s2       = hit_s2;
        bad_zero    = hit_s2 && staged_mode_q && (wr_data == '0);
        mode_next   = bad_zero ? mode : staged_mode_q;
        commit      = do_s1 || do_s2;
        commit_long = do_s1 || (do_s2 && mode_next);
    end

    // staging and committed registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_in_q   <= '0;
            staged_mode_q <= 1'b0;
            s1_in         <= '0;
            s1_fb         <= '0;
            s2_in         <= '0;
            s2_fb         <= '0;
            mode          <= 1'b0;
            order_err     <= 1'b0;
            cfg_err       <= 1'b0;
        end else begin
            if (hit_in)   staged_in_q   <= wr_data;
            if (hit_mode) staged_mode_q <= wr_data[0];
            if (do_s1) begin
                s1_in <= staged_in_q;
                s1_fb <= wr_data;
            end
            if (do_s2) begin
                s2_in <= wr_data[DW-1:HW];
                s2_fb <= wr_data[HW-1:0];
                mode  <= mode_next;
            end
            if (oerr_set) order_err <= 1'b1;
            if (bad_zero) cfg_err   <= 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_lock.sv
module clkdiv_lock
    import clkdiv_pkg::*;
#(
    parameter int LONG_CYC  = 20000,
    parameter int SHORT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_long,
    output logic busy,
    output logic ready
);
    localparam int CW = $clog2(LONG_CYC + 1);

    lock_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          long_q, long_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_WAIT;
            cnt_q   <= CW'(LONG_CYC);
            long_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            long_q  <= long_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        long_d  = long_q;
        if (start) begin
            state_d = LK_WAIT;
            long_d  = start_long || ((state_q == LK_WAIT) && long_q);
            cnt_d   = long_d ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        end else begin
            unique case (state_q)
                LK_WAIT: begin
                    if (cnt_q == CW'(1)) state_d = LK_LOCKED;
                    else                 cnt_d   = cnt_q - CW'(1);
                end
                LK_LOCKED: ;
                default: state_d = LK_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q == LK_WAIT);
        ready = !busy;
    end

endmodule

// File: rtl/clkdiv_cmpchk.sv
module clkdiv_cmpchk #(
    parameter int DW         = 8,
    parameter int MCLK_HZ    = 20_000_000,
    parameter int MIN_CMP_HZ = 144_000
) (
    input  logic [DW-1:0] div_val,
    output logic          too_low
);
    logic [63:0] need_hz;

    always_comb begin
        need_hz = 64'(MIN_CMP_HZ) * (64'(div_val) + 64'd1);
        too_low = 64'(MCLK_HZ) < need_hz;
    end

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int A_S1IN     = 7,
    parameter int A_S1FB     = 8,
    parameter int A_S2       = 9,
    parameter int A_MODE     = 10,
    parameter int MCLK_HZ    = 20_000_000,
    parameter int CYC_PER_US = MCLK_HZ / 1_000_000,
    parameter int LONG_US    = 1000,
    parameter int SHORT_US   = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   stage1_in_div,
    output logic [DW-1:0]   stage1_fb_div,
    output logic [DW/2-1:0] stage2_in_div,
    output logic [DW/2-1:0] stage2_fb_div,
    output logic            ratio_mode,
    output logic            busy,
    output logic            ready,
    output logic            order_err,
    output logic            cfg_err,
    output logic            cmp_freq_low
);
    localparam int LONG_CYC  = LONG_US * CYC_PER_US;
    localparam int SHORT_CYC = SHORT_US * CYC_PER_US;

    logic commit, commit_long;

    clkdiv_seq #(
        .AW(AW), .DW(DW), .A_S1IN(A_S1IN), .A_S1FB(A_S1FB),
        .A_S2(A_S2), .A_MODE(A_MODE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .s1_in(stage1_in_div), .s1_fb(stage1_fb_div),
        .s2_in(stage2_in_div), .s2_fb(stage2_fb_div),
        .mode(ratio_mode), .order_err(order_err), .cfg_err(cfg_err),
        .commit(commit), .commit_long(commit_long)
    );

    clkdiv_lock #(
        .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
    ) u_lock (
        .clk(clk), .rst_n(rst_n),
        .start(commit), .start_long(commit_long),
        .busy(busy), .ready(ready)
    );

    clkdiv_cmpchk #(
        .DW(DW), .MCLK_HZ(MCLK_HZ), .MIN_CMP_HZ(144_000)
    ) u_cmp (
        .div_val(stage1_in_div),
        .too_low(cmp_freq_low)
    );

endmodule

// File: rtl/clkdiv_ctrl_chk.sv
module clkdiv_ctrl_chk #(
    parameter int AW     = 4,
    parameter int DW     = 8,
    parameter int A_S1FB = 8,
    parameter int A_S2   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   stage1_in_div,
    input logic [DW-1:0]   stage1_fb_div,
    input logic            ratio_mode,
    input logic            busy,
    input logic            order_err,
    input logic            cfg_err
);
    // R2: first-stage outputs move only after a feedback-divider write
    p_s1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(A_S1FB)) |=>
            ($stable(stage1_in_div) && $stable(stage1_fb_div)));

    // R3: mode changes only after a second-stage write
    p_mode_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(A_S2)) |=> $stable(ratio_mode));

    // R6: a second-stage commit always opens a lock window
    p_busy_after_s2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(A_S2)) |=> busy);

    // R5: order error is sticky
    p_order_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);

    // R8: configuration error is sticky
    p_cfg_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

bind clkdiv_ctrl clkdiv_ctrl_chk #(
    .AW(AW), .DW(DW), .A_S1FB(A_S1FB), .A_S2(A_S2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .stage1_in_div(stage1_in_div), .stage1_fb_div(stage1_fb_div),
    .ratio_mode(ratio_mode), .busy(busy),
    .order_err(order_err), .cfg_err(cfg_err)
);

// File: tb/clkdiv_ctrl_tb.sv
`timescale 1ns/1ps
module clkdiv_ctrl_tb;
    localparam int MCLK  = 2_000_000;
    localparam int LONGW = 1000 * 2;
    localparam int SHRTW = 100 * 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] s1_in, s1_fb;
    logic [3:0] s2_in, s2_fb;
    logic       ratio_mode, busy, ready, order_err, cfg_err, cmp_freq_low;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clkdiv_ctrl #(.MCLK_HZ(MCLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data),
        .stage1_in_div(s1_in), .stage1_fb_div(s1_fb),
        .stage2_in_div(s2_in), .stage2_fb_div(s2_fb),
        .ratio_mode(ratio_mode), .busy(busy), .ready(ready),
        .order_err(order_err), .cfg_err(cfg_err),
        .cmp_freq_low(cmp_freq_low)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called right after wr() returns: busy for w cycles, then ready
    task automatic check_window(int w, string req);
        repeat (w - 1) @(negedge clk);
        check(req, "busy before expiry", 32'(busy), 1);
        @(negedge clk);
        check(req, "ready at expiry", 32'(ready), 1);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "s1_in", 32'(s1_in), 0);
        check("R1", "s1_fb", 32'(s1_fb), 0);
        check("R1", "s2 pair", 32'({s2_in, s2_fb}), 0);
        check("R1", "mode", 32'(ratio_mode), 0);
        check("R1", "flags", 32'({order_err, cfg_err}), 0);
        check("R1", "ready low", 32'(ready), 0);
        rst_n = 1'b1;
        check_window(LONGW, "R1");
    endtask

    task automatic t_stage1_pair();
        wr(4'd7, 8'h0A);
        repeat (3) @(negedge clk);
        check("R2", "s1_in before pair done", 32'(s1_in), 0);
        wr(4'd8, 8'h5F);
        check("R2", "s1_in", 32'(s1_in), 32'h0A);
        check("R2", "s1_fb", 32'(s1_fb), 32'h5F);
        check_window(LONGW, "R6");
    endtask

    task automatic t_mode_defer();
        wr(4'd10, 8'h01);
        repeat (5) @(negedge clk);
        check("R3", "mode deferred", 32'(ratio_mode), 0);
        wr(4'd9, 8'h35);
        check("R3", "mode applied", 32'(ratio_mode), 1);
        check("R4", "s2_in", 32'(s2_in), 3);
        check("R4", "s2_fb", 32'(s2_fb), 5);
        check_window(LONGW, "R6");
        wr(4'd10, 8'h00);
        check("R3", "mode held", 32'(ratio_mode), 1);
        wr(4'd9, 8'h12);
        check("R3", "mode cleared", 32'(ratio_mode), 0);
        check("R4", "s2 pair", 32'({s2_in, s2_fb}), 32'h12);
        check_window(SHRTW, "R6");
    endtask

    task automatic t_restart_longer();
        wr(4'd7, 8'h05);
        wr(4'd8, 8'h06);
        repeat (10) @(negedge clk);
        wr(4'd9, 8'h44);
        check_window(LONGW, "R7");
    endtask

    task automatic t_order_break();
        check("R5", "order_err clear", 32'(order_err), 0);
        wr(4'd7, 8'h0B);
        wr(4'd9, 8'h21);
        check("R5", "order_err set", 32'(order_err), 1);
        check("R5", "interrupting write applied", 32'({s2_in, s2_fb}), 32'h21);
        wr(4'd8, 8'h22);
        check("R5", "s1_in unchanged", 32'(s1_in), 32'h05);
        check("R5", "s1_fb unchanged", 32'(s1_fb), 32'h06);
        wait_ready();
    endtask

    task automatic t_cmp_check();
        wr(4'd7, 8'd12);
        wr(4'd8, 8'h10);
        check("R9", "12 within limit", 32'(cmp_freq_low), 0);
        wr(4'd7, 8'd13);
        wr(4'd8, 8'h10);
        check("R9", "13 below limit", 32'(cmp_freq_low), 1);
        wait_ready();
    endtask

    task automatic t_zero_cfg();
        check("R8", "cfg_err clear", 32'(cfg_err), 0);
        wr(4'd10, 8'h01);
        wr(4'd9, 8'h00);
        check("R8", "cfg_err set", 32'(cfg_err), 1);
        check("R8", "mode kept", 32'(ratio_mode), 0);
        check("R8", "s2 pair zero", 32'({s2_in, s2_fb}), 0);
        check_window(SHRTW, "R8");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_stage1_pair();
        t_mode_defer();
        t_restart_longer();
        t_order_break();
        t_cmp_check();
        t_zero_cfg();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule